// File: doc/BRIEF.md
# Half-duplex serial command responder

This block is the peripheral end of a MICROWIRE link. While the chip-select line is held low, it takes in an 8-bit control byte from the controller, most significant bit first. It then lets one full serial clock pass as a decode slot and answers with a reply word of 4 to 16 bits on its output line. The output line is driven only while that reply is being sent. At all other times the output enable is low, so the pad can float.

The reply word comes from a 256-entry register file, indexed by the captured control byte. A parallel write port loads this file. The captured byte is also shown on a parallel output, together with a one-cycle strobe. The controller may keep chip-select low and start the next control byte directly after the last reply bit. Raising chip-select at any point ends the frame.

All serial pins are sampled by the fast system clock through a synchronizer. The serial clock must therefore be much slower than the system clock: each serial clock phase must last at least six system clock periods. Serial clock idles low.

Top module: `mw_responder`

## Requirements
- R1: While reset is high and on the cycle after it, `poci_oe_o` and `cmd_valid_o` are 0.
- R2: Eight rising edges of `sclk_i` with `cs_n_i` low capture `pico_i`, first bit as bit 7 of the byte. `cmd_o` then holds that byte, and `cmd_valid_o` is high for exactly one system cycle per captured byte.
- R3: The output enable stays 0 through the rising edge that follows the eighth control bit (the decode slot). It goes high only in response to a falling edge of `sclk_i`.
- R4: Reply bits are changed only on falling edges of `sclk_i`. The first one is driven on the falling edge after the decode slot, so the controller sees reply bit L-1 down to bit 0 of table[byte] on the next L rising edges.
- R5: The reply length L is taken from `len_i` when the control byte is completed. Values below 4 act as 4, and values above 16 act as 16.
- R6: `poci_oe_o` is 1 only during the reply. It drops on the falling edge after the controller has sampled the last reply bit, and it is 0 throughout the control byte.
- R7: With `cs_n_i` still low after a reply, the next rising edge begins a new control byte, and that frame is answered like the first.
- R8: A high level on `cs_n_i` at any point releases the output and resets the bit counter. The next frame is then captured from its first bit.
- R9: A write through `tbl_we_i`/`tbl_addr_i`/`tbl_wdata_i` changes the reply that later frames return for that address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous active-high reset |
| sclk_i | input | 1 | Serial clock from the controller |
| cs_n_i | input | 1 | Active-low frame select |
| pico_i | input | 1 | Serial data from the controller |
| poci_o | output | 1 | Serial reply data |
| poci_oe_o | output | 1 | Pad drive enable for poci_o |
| len_i | input | 5 | Configured reply length in bits |
| cmd_o | output | 8 | Last captured control byte |
| cmd_valid_o | output | 1 | One-cycle strobe for a new byte |
| tbl_we_i | input | 1 | Reply table write enable |
| tbl_addr_i | input | 8 | Reply table write address |
| tbl_wdata_i | input | 16 | Reply table write data |

## Verification
On every cycle, the assertions check the following:
- The output enable only rises on a serial falling edge.
- Reply data stays still between falling edges.
- The latched reply length stays within 4 to 16.
- A high chip-select always releases the line.
- The byte strobe never lasts two cycles.

The bench scenarios cover what needs a whole frame to observe: the bit order of capture and reply, the exact position of the decode slot, clamping of out-of-range lengths, back-to-back frames, aborts both in the command byte and in the reply, and table rewrites.

// File: rtl/mw_pkg.sv
package mw_pkg;

    localparam int CMD_W       = 8;
    localparam int REPLY_W_MIN = 4;
    localparam int REPLY_W_MAX = 16;
    localparam int LEN_W       = $clog2(REPLY_W_MAX + 1);

    typedef enum logic [1:0] {
        PH_CMD,
        PH_DECODE,
        PH_ARM,
        PH_REPLY
    } mw_phase_e;

    typedef struct packed {
        logic rise;
        logic fall;
        logic cs_idle;
        logic data;
    } mw_pins_t;

    function automatic logic [LEN_W-1:0] clamp_len(input logic [LEN_W-1:0] raw);
        if (raw < LEN_W'(REPLY_W_MIN)) return LEN_W'(REPLY_W_MIN);
        if (raw > LEN_W'(REPLY_W_MAX)) return LEN_W'(REPLY_W_MAX);
        return raw;
    endfunction

endpackage

// File: rtl/mw_pin_sync.sv
module mw_pin_sync
    import mw_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk_i,
    input  logic     rst_i,
    input  logic     sclk_i,
    input  logic     cs_n_i,
    input  logic     pico_i,
    output mw_pins_t pins_o
);
    localparam int NPIN = 3;
    localparam logic [NPIN-1:0] RST_VAL = 3'b010;

    logic [NPIN-1:0] raw;
    logic [NPIN-1:0] synced;
    logic            sclk_prev;

    assign raw = {sclk_i, cs_n_i, pico_i};

    for (genvar p = 0; p < NPIN; p++) begin : g_pin
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk_i) begin
            if (rst_i) chain <= {STAGES{RST_VAL[p]}};
            else       chain <= {chain[STAGES-2:0], raw[p]};
        end
        assign synced[p] = chain[STAGES-1];
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) sclk_prev <= 1'b0;
        else       sclk_prev <= synced[2];
    end

    always_comb begin
        pins_o.rise    = synced[2] & ~sclk_prev;
        pins_o.fall    = ~synced[2] & sclk_prev;
        pins_o.cs_idle = synced[1];
        pins_o.data    = synced[0];
    end

endmodule

// File: rtl/mw_reply_table.sv
module mw_reply_table #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16
) (
    input  logic              clk_i,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] waddr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [ADDR_W-1:0] raddr_i,
    output logic [DATA_W-1:0] rdata_o
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk_i) begin
        if (we_i) mem[waddr_i] <= wdata_i;
    end

    assign rdata_o = mem[raddr_i];

endmodule

// File: rtl/mw_engine.sv
module mw_engine
    import mw_pkg::*;
#(
    parameter int CMDW   = CMD_W,
    parameter int DATA_W = REPLY_W_MAX
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  mw_pins_t          pins_i,
    input  logic [LEN_W-1:0]  len_cfg_i,
    output logic [CMDW-1:0]   rd_addr_o,
    input  logic [DATA_W-1:0] rd_data_i,
    output logic [CMDW-1:0]   cmd_o,
    output logic              cmd_valid_o,
    output logic              poci_o,
    output logic              poci_oe_o,
    output logic [LEN_W-1:0]  len_o
);
    localparam int CNT_W = $clog2(DATA_W + 1);

    mw_phase_e         phase_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [CMDW-1:0]   shreg_q;
    logic [DATA_W-1:0] word_q;
    logic [DATA_W-1:0] tx_q;
    logic [DATA_W-1:0] aligned;
    logic [CMDW-1:0]   next_byte;

    assign next_byte = {shreg_q[CMDW-2:0], pins_i.data};
    assign rd_addr_o = next_byte;
    assign aligned   = word_q << (DATA_W - int'(len_o));
    assign poci_o    = tx_q[DATA_W-1];

    always_ff @(posedge clk_i) begin
        if (rst_i || pins_i.cs_idle) begin
            phase_q     <= PH_CMD;
            cnt_q       <= '0;
            poci_oe_o   <= 1'b0;
            cmd_valid_o <= 1'b0;
            if (rst_i) begin
                shreg_q <= '0;
                cmd_o   <= '0;
                word_q  <= '0;
                tx_q    <= '0;
                len_o   <= LEN_W'(REPLY_W_MIN);
            end
        end else begin
            cmd_valid_o <= 1'b0;
            unique case (phase_q)
                PH_CMD: if (pins_i.rise) begin
                    shreg_q <= next_byte;
                    if (cnt_q == CNT_W'(CMDW - 1)) begin
                        cmd_o       <= next_byte;
                        cmd_valid_o <= 1'b1;
                        word_q      <= rd_data_i;
                        len_o       <= clamp_len(len_cfg_i);
                        cnt_q       <= '0;
                        phase_q     <= PH_DECODE;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                PH_DECODE: if (pins_i.rise) phase_q <= PH_ARM;
                PH_ARM: if (pins_i.fall) begin
                    tx_q      <= aligned;
                    poci_oe_o <= 1'b1;
                    cnt_q     <= CNT_W'(int'(len_o) - 1);
                    phase_q   <= PH_REPLY;
                end
                PH_REPLY: if (pins_i.fall) begin
                    if (cnt_q == '0) begin
                        poci_oe_o <= 1'b0;
                        phase_q   <= PH_CMD;
                    end else begin
                        tx_q  <= tx_q << 1;
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                default: phase_q <= PH_CMD;
            endcase
        end
    end

endmodule

// File: rtl/mw_responder.sv
module mw_responder
    import mw_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int DATA_W      = REPLY_W_MAX
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              sclk_i,
    input  logic              cs_n_i,
    input  logic              pico_i,
    output logic              poci_o,
    output logic              poci_oe_o,
    input  logic [LEN_W-1:0]  len_i,
    output logic [CMD_W-1:0]  cmd_o,
    output logic              cmd_valid_o,
    input  logic              tbl_we_i,
    input  logic [CMD_W-1:0]  tbl_addr_i,
    input  logic [DATA_W-1:0] tbl_wdata_i
);
    mw_pins_t          pins;
    logic [CMD_W-1:0]  rd_addr;
    logic [DATA_W-1:0] rd_data;
    logic [LEN_W-1:0]  reply_len;
    logic              cs_n_s;
    logic              sclk_fall;

    assign cs_n_s    = pins.cs_idle;
    assign sclk_fall = pins.fall;

    mw_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .sclk_i (sclk_i),
        .cs_n_i (cs_n_i),
        .pico_i (pico_i),
        .pins_o (pins)
    );

    mw_reply_table #(.ADDR_W(CMD_W), .DATA_W(DATA_W)) u_table (
        .clk_i   (clk_i),
        .we_i    (tbl_we_i),
        .waddr_i (tbl_addr_i),
        .wdata_i (tbl_wdata_i),
        .raddr_i (rd_addr),
        .rdata_o (rd_data)
    );

    mw_engine #(.CMDW(CMD_W), .DATA_W(DATA_W)) u_engine (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .pins_i      (pins),
        .len_cfg_i   (len_i),
        .rd_addr_o   (rd_addr),
        .rd_data_i   (rd_data),
        .cmd_o       (cmd_o),
        .cmd_valid_o (cmd_valid_o),
        .poci_o      (poci_o),
        .poci_oe_o   (poci_oe_o),
        .len_o       (reply_len)
    );

endmodule

// File: rtl/mw_responder_chk.sv
module mw_responder_chk
    import mw_pkg::*;
(
    input logic             clk_i,
    input logic             rst_i,
    input logic             cs_n_s,
    input logic             sclk_fall,
    input logic             poci_o,
    input logic             poci_oe_o,
    input logic             cmd_valid_o,
    input logic [LEN_W-1:0] reply_len
);
    AST_RESET_QUIET: assert property (@(posedge clk_i)
        $past(rst_i) |-> (!poci_oe_o && !cmd_valid_o)); // R1

    AST_STROBE_SINGLE: assert property (@(posedge clk_i) disable iff (rst_i)
        cmd_valid_o |=> !cmd_valid_o); // R2

    AST_DRIVE_ON_FALL: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(poci_oe_o) |-> $past(sclk_fall)); // R3

    AST_DATA_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
        (poci_oe_o && $past(poci_oe_o) && !$past(sclk_fall)) |-> $stable(poci_o)); // R4

    AST_LEN_RANGE: assert property (@(posedge clk_i) disable iff (rst_i)
        (reply_len >= LEN_W'(REPLY_W_MIN)) && (reply_len <= LEN_W'(REPLY_W_MAX))); // R5

    AST_CS_RELEASE: assert property (@(posedge clk_i) disable iff (rst_i)
        cs_n_s |=> !poci_oe_o); // R8

endmodule

bind mw_responder mw_responder_chk u_chk (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .cs_n_s      (cs_n_s),
    .sclk_fall   (sclk_fall),
    .poci_o      (poci_o),
    .poci_oe_o   (poci_oe_o),
    .cmd_valid_o (cmd_valid_o),
    .reply_len   (reply_len)
);

// File: tb/mw_responder_tb.sv
module mw_responder_tb;
    logic        clk = 1'b0;
    logic        rst_i = 1'b1;
    logic        sclk_i = 1'b0;
    logic        cs_n_i = 1'b1;
    logic        pico_i = 1'b0;
    logic        poci_o;
    logic        poci_oe_o;
    logic [4:0]  len_i = 5'd16;
    logic [7:0]  cmd_o;
    logic        cmd_valid_o;
    logic        tbl_we_i = 1'b0;
    logic [7:0]  tbl_addr_i = '0;
    logic [15:0] tbl_wdata_i = '0;

    int n_chk = 0;
    int n_fail = 0;
    int strobes = 0;
    bit done = 1'b0;
    logic [15:0] model_tab [256];

    always #2.5 clk = ~clk;

    mw_responder u_dut (
        .clk_i(clk), .rst_i(rst_i), .sclk_i(sclk_i), .cs_n_i(cs_n_i),
        .pico_i(pico_i), .poci_o(poci_o), .poci_oe_o(poci_oe_o),
        .len_i(len_i), .cmd_o(cmd_o), .cmd_valid_o(cmd_valid_o),
        .tbl_we_i(tbl_we_i), .tbl_addr_i(tbl_addr_i), .tbl_wdata_i(tbl_wdata_i)
    );

    always @(negedge clk) if (!rst_i && cmd_valid_o) strobes++;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tbl_write(input logic [7:0] a, input logic [15:0] d);
        @(negedge clk);
        tbl_we_i = 1'b1; tbl_addr_i = a; tbl_wdata_i = d;
        @(negedge clk);
        tbl_we_i = 1'b0;
        model_tab[a] = d;
    endtask

    function automatic int eff_len(input int l);
        return (l < 4) ? 4 : ((l > 16) ? 16 : l);
    endfunction

    // One frame as seen by the controller; the reference model is the
    // expected bit queue built from the model table.
    task automatic xfer(input logic [7:0] cmd, input int len_cfg, input bit hold,
                        input bit chained, input string rtag);
        int n = eff_len(len_cfg);
        int s0 = strobes;
        bit q[$];
        for (int k = n - 1; k >= 0; k--) q.push_back(model_tab[cmd][k]);
        @(negedge clk);
        len_i = 5'(len_cfg);
        cs_n_i = 1'b0;
        pico_i = cmd[7];
        for (int r = 1; r <= 9 + n; r++) begin
            repeat (6) @(negedge clk);
            if (r <= 9) begin
                check(poci_oe_o == 1'b0,
                      (r == 1 && chained) ? "R7" : ((r == 9) ? "R3" : "R6"),
                      int'(poci_oe_o), 0);
            end else begin
                bit e = q.pop_front();
                check(poci_oe_o == 1'b1, "R6", int'(poci_oe_o), 1);
                check(poci_o == e, rtag, int'(poci_o), int'(e));
            end
            @(negedge clk);
            sclk_i = 1'b1;
            repeat (7) @(negedge clk);
            if (r == 8) begin
                check(cmd_o == cmd, chained ? "R7" : "R2", int'(cmd_o), int'(cmd));
                check(strobes == s0 + 1, "R2", strobes - s0, 1);
            end
            @(negedge clk);
            sclk_i = 1'b0;
            pico_i = (r < 8) ? cmd[7 - r] : 1'b0;
        end
        if (!hold) begin
            repeat (6) @(negedge clk);
            check(poci_oe_o == 1'b0, "R6", int'(poci_oe_o), 0);
            cs_n_i = 1'b1;
            repeat (10) @(negedge clk);
        end
    endtask

    task automatic abort_after(input logic [7:0] cmd, input int rises);
        @(negedge clk);
        len_i = 5'd16;
        cs_n_i = 1'b0;
        pico_i = cmd[7];
        for (int r = 1; r <= rises; r++) begin
            repeat (7) @(negedge clk);
            sclk_i = 1'b1;
            repeat (8) @(negedge clk);
            sclk_i = 1'b0;
            pico_i = (r < 8) ? cmd[7 - r] : 1'b0;
        end
        repeat (6) @(negedge clk);
        if (rises > 9) check(poci_oe_o == 1'b1, "R6", int'(poci_oe_o), 1);
        cs_n_i = 1'b1;
        repeat (6) @(negedge clk);
        check(poci_oe_o == 1'b0, "R8", int'(poci_oe_o), 0);
        repeat (10) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : stimulus
        repeat (4) @(negedge clk);
        check(poci_oe_o == 1'b0, "R1", int'(poci_oe_o), 0);
        check(cmd_valid_o == 1'b0, "R1", int'(cmd_valid_o), 0);
        rst_i = 1'b0;
        @(negedge clk);
        check(poci_oe_o == 1'b0 && cmd_valid_o == 1'b0, "R1",
              int'({poci_oe_o, cmd_valid_o}), 0);

        for (int i = 0; i < 256; i++)
            tbl_write(8'(i), 16'((i * 40503) ^ (i << 3) ^ 16'h3C5A));

        xfer(8'hA5, 16, 1'b0, 1'b0, "R4");
        xfer(8'h3C, 8, 1'b0, 1'b0, "R4");
        xfer(8'h01, 4, 1'b0, 1'b0, "R4");
        xfer(8'hFF, 2, 1'b0, 1'b0, "R5");
        xfer(8'h80, 20, 1'b0, 1'b0, "R5");

        xfer(8'h5A, 12, 1'b1, 1'b0, "R4");
        xfer(8'hC3, 5, 1'b1, 1'b1, "R7");
        xfer(8'h0F, 16, 1'b0, 1'b1, "R7");

        abort_after(8'h77, 4);
        xfer(8'h77, 10, 1'b0, 1'b0, "R8");
        abort_after(8'h66, 12);
        xfer(8'h66, 9, 1'b0, 1'b0, "R8");

        tbl_write(8'h3C, 16'hBEEF);
        xfer(8'h3C, 16, 1'b0, 1'b0, "R9");
        tbl_write(8'h3C, 16'h0123);
        xfer(8'h3C, 12, 1'b0, 1'b0, "R9");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule